// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Strobe Cycle Decoder

This block is a clocked model of the control logic inside a four-bit-wide fast-page-mode DRAM. It runs from a clock that is much faster than the memory strobes. On each clock it samples the row strobe, column strobe, write enable, output enable and a multiplexed address bus. From the order in which the strobes fall, it decides what kind of memory cycle the controller is running. The strobe inputs are active low.

It latches the row and the column, issues write strobes with their data and read enables, and decides when the data pins are driven. It also keeps the internal refresh-row counter and reports refresh events and self-refresh residency. A small behavioural array, indexed by the low bits of the latched row and column, stores the written data so that reads return real values. A controller model or a memory-interface testbench can use it as a cycle-accurate stand-in for the memory device.

Two geometries are selectable. In the wide-row geometry there are 12 row bits and 10 column bits. In the balanced geometry there are 11 row bits and 11 column bits.

Top module: `fpm_strobe_decoder`

## Requirements
- R1: Reset behaviour. While reset is low, and on the first cycle after it, all of the following are zero: `dq_oe`, `rd_en`, `wr_stb`, `rfsh_stb`, `self_rfsh`, `rfsh_cnt` and `cyc_type`.
- R2: Row latch. When the row strobe is sampled falling while the column strobe is high, `row_q` takes the address masked to the row width: 12 bits when `MODE_4K`=1, 11 bits when `MODE_4K`=0.
- R3: Column latch. When the column strobe falls inside an open row, `col_q` takes the address masked to the column width: 10 bits when `MODE_4K`=1 (address bits 10 and 11 are ignored), 11 bits when `MODE_4K`=0.
- R4: Read. A column fall with write enable high pulses `rd_en` for one cycle and sets `cyc_type`=1. It loads the stored word onto `dq_out`. `dq_oe` is high from that same cycle while output enable is low.
- R5: Early write. If write enable is already low when the column strobe falls, the word on `dq_in` is stored at that fall. `wr_stb` pulses once with `wr_data` equal to that word, and `cyc_type`=2. `dq_oe` stays low for the whole column cycle, even with output enable low.
- R6: Late write. If write enable falls while the column strobe is low and output enable is high, `dq_in` is stored at that fall and `wr_stb` pulses once. `cyc_type` is 3 when output enable was not low earlier in that column cycle.
- R7: Read-modify-write. This is the same write as R6, but output enable was low earlier in that column cycle. Here `cyc_type`=4.
- R8: Blocked late write. If write enable falls after the column strobe while output enable is low, nothing is written, no `wr_stb` pulse occurs, and `dq_out` keeps driving the word that was read.
- R9: Page mode. While the row strobe stays low, each further column fall accesses the same latched row at a new column. A column fall while the row strobe is high performs no access.
- R10: Counter refresh. If the column strobe is low when the row strobe falls, `rfsh_stb` pulses with `rfsh_row` equal to the counter's previous value, and the counter advances by one, wrapping at the row width. The address pins and `row_q` are left untouched, and `cyc_type`=6.
- R11: Hidden refresh. If the column strobe is held low from an access through a row precharge and a new row fall, a counter refresh runs as in R10 with `cyc_type`=7. `dq_oe` and `dq_out` keep presenting the earlier read word.
- R12: Row-only refresh. A row-strobe low period with no column fall ends, on the row rise, with an `rfsh_stb` pulse whose `rfsh_row` equals `row_q`, and `cyc_type`=5. `dq_oe` stays low and the counter does not change.
- R13: Self refresh. A counter-refresh cycle whose row strobe stays low sets `self_rfsh` on the edge `SELF_CYC` clocks after the row-fall sample. `self_rfsh` clears on the row rise.
- R14: Output gating. `dq_oe` is low whenever output enable is high, or the column strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data from the data pins |
| dq_out | output | DQ_W | Read data toward the data pins |
| dq_oe | output | 1 | Data pin drive enable |
| row_q | output | ADDR_W | Latched row |
| col_q | output | ADDR_W | Latched column |
| rd_en | output | 1 | One-cycle read pulse |
| wr_stb | output | 1 | One-cycle write pulse |
| wr_data | output | DQ_W | Word stored by the last write |
| rfsh_stb | output | 1 | One-cycle refresh pulse |
| rfsh_row | output | ADDR_W | Row refreshed by the last pulse |
| rfsh_cnt | output | ADDR_W | Internal refresh-row counter |
| self_rfsh | output | 1 | Self-refresh active |
| cyc_type | output | 3 | Last cycle class: 0 idle, 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 row-only refresh, 6 counter refresh, 7 hidden refresh |

## Verification
The bench builds two copies that share the same stimulus. The main copy uses `MODE_4K`=1 and `SELF_CYC`=40. With that short entry delay, the exact clock on which self refresh begins can be checked within a few dozen cycles instead of the default 12,500. The second copy uses `MODE_4K`=0, so each row and column latch is compared under both address splits, including the two upper column bits that the wide-row geometry discards. The array keeps the default three row and three column index bits, so written words at distinct columns of one row can be read back through page cycles.

// File: rtl/fpm_strobe_decoder.sv
`timescale 1ns/1ps
module fpm_strobe_decoder #(
  parameter int ADDR_W       = 12,
  parameter int DQ_W         = 4,
  parameter int MODE_4K      = 1,
  parameter int MEM_ROW_BITS = 3,
  parameter int MEM_COL_BITS = 3,
  parameter int SELF_CYC     = 12500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic [ADDR_W-1:0] row_q,
  output logic [ADDR_W-1:0] col_q,
  output logic              rd_en,
  output logic              wr_stb,
  output logic [DQ_W-1:0]   wr_data,
  output logic              rfsh_stb,
  output logic [ADDR_W-1:0] rfsh_row,
  output logic [ADDR_W-1:0] rfsh_cnt,
  output logic              self_rfsh,
  output logic [2:0]        cyc_type
);
  localparam int ROW_W = (MODE_4K != 0) ? ADDR_W : ADDR_W - 1;
  localparam int COL_W = (MODE_4K != 0) ? ADDR_W - 2 : ADDR_W - 1;
  localparam logic [ADDR_W-1:0] ROW_MASK = {ADDR_W{1'b1}} >> (ADDR_W - ROW_W);
  localparam logic [ADDR_W-1:0] COL_MASK = {ADDR_W{1'b1}} >> (ADDR_W - COL_W);
  localparam int IDX_W = MEM_ROW_BITS + MEM_COL_BITS;
  localparam int DEPTH = 1 << IDX_W;
  localparam int SC_W  = $clog2(SELF_CYC + 1);
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(SELF_CYC - 1);

  localparam logic [2:0] CT_READ   = 3'd1;
  localparam logic [2:0] CT_EARLY  = 3'd2;
  localparam logic [2:0] CT_LATE   = 3'd3;
  localparam logic [2:0] CT_RMW    = 3'd4;
  localparam logic [2:0] CT_RONLY  = 3'd5;
  localparam logic [2:0] CT_CBR    = 3'd6;
  localparam logic [2:0] CT_HIDDEN = 3'd7;

  logic ras_q, cas_q, we_q;
  logic row_open, cbr_act, col_seen, cas_acc;
  logic early_wr, late_done, dvalid, oe_seen;
  logic [SC_W-1:0] self_cnt;
  logic [DQ_W-1:0] dout;
  logic [DQ_W-1:0] mem [DEPTH];

  wire ras_fall = ras_q & ~ras_n;
  wire ras_rise = ~ras_q & ras_n;
  wire cas_fall = cas_q & ~cas_n;
  wire cas_rise = ~cas_q & cas_n;
  wire we_fall  = we_q & ~we_n;

  wire [ADDR_W-1:0] row_pins = addr & ROW_MASK;
  wire [ADDR_W-1:0] col_pins = addr & COL_MASK;

  wire acc_cas_fall = cas_fall & row_open & ~ras_n;
  wire early_hit    = acc_cas_fall & ~we_n;
  wire late_we      = we_fall & ~cas_n & ~cas_q & cas_acc & row_open &
                      ~early_wr & ~late_done;
  wire late_write   = late_we & oe_n;

  wire [IDX_W-1:0] acc_idx  = {row_q[MEM_ROW_BITS-1:0], col_pins[MEM_COL_BITS-1:0]};
  wire [IDX_W-1:0] late_idx = {row_q[MEM_ROW_BITS-1:0], col_q[MEM_COL_BITS-1:0]};
  wire             mem_we   = early_hit | late_write;
  wire [IDX_W-1:0] mem_widx = early_hit ? acc_idx : late_idx;

  assign dq_out = dout;
  assign dq_oe  = ~cas_n & ~oe_n & dvalid & ~early_wr & ~late_done;

  always_ff @(posedge clk)
    if (mem_we) mem[mem_widx] <= dq_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q     <= 1'b1;
      cas_q     <= 1'b1;
      we_q      <= 1'b1;
      row_open  <= 1'b0;
      cbr_act   <= 1'b0;
      col_seen  <= 1'b0;
      cas_acc   <= 1'b0;
      early_wr  <= 1'b0;
      late_done <= 1'b0;
      dvalid    <= 1'b0;
      oe_seen   <= 1'b0;
      self_cnt  <= '0;
      self_rfsh <= 1'b0;
      dout      <= '0;
      row_q     <= '0;
      col_q     <= '0;
      rd_en     <= 1'b0;
      wr_stb    <= 1'b0;
      wr_data   <= '0;
      rfsh_stb  <= 1'b0;
      rfsh_row  <= '0;
      rfsh_cnt  <= '0;
      cyc_type  <= '0;
    end else begin
      ras_q    <= ras_n;
      cas_q    <= cas_n;
      we_q     <= we_n;
      rd_en    <= 1'b0;
      wr_stb   <= 1'b0;
      rfsh_stb <= 1'b0;

      if (ras_fall) begin
        if (!cas_n) begin
          cbr_act  <= 1'b1;
          self_cnt <= '0;
          rfsh_stb <= 1'b1;
          rfsh_row <= rfsh_cnt;
          rfsh_cnt <= (rfsh_cnt + 1'b1) & ROW_MASK;
          cyc_type <= cas_acc ? CT_HIDDEN : CT_CBR;
        end else begin
          row_open <= 1'b1;
          col_seen <= 1'b0;
          row_q    <= row_pins;
        end
      end

      if (ras_rise) begin
        row_open  <= 1'b0;
        cbr_act   <= 1'b0;
        self_rfsh <= 1'b0;
        if (row_open && !col_seen) begin
          rfsh_stb <= 1'b1;
          rfsh_row <= row_q;
          cyc_type <= CT_RONLY;
        end
      end

      if (cbr_act && !ras_n && !ras_fall && !self_rfsh) begin
        if (self_cnt == SC_LAST) self_rfsh <= 1'b1;
        else                     self_cnt  <= self_cnt + 1'b1;
      end

      if (cas_acc && !cas_n && !cas_q && !oe_n) oe_seen <= 1'b1;

      if (acc_cas_fall) begin
        col_q     <= col_pins;
        col_seen  <= 1'b1;
        cas_acc   <= 1'b1;
        late_done <= 1'b0;
        oe_seen   <= 1'b0;
        if (!we_n) begin
          early_wr <= 1'b1;
          dvalid   <= 1'b0;
          wr_stb   <= 1'b1;
          wr_data  <= dq_in;
          cyc_type <= CT_EARLY;
        end else begin
          early_wr <= 1'b0;
          dvalid   <= 1'b1;
          rd_en    <= 1'b1;
          dout     <= mem[acc_idx];
          cyc_type <= CT_READ;
        end
      end

      if (late_write) begin
        wr_stb    <= 1'b1;
        wr_data   <= dq_in;
        late_done <= 1'b1;
        cyc_type  <= oe_seen ? CT_RMW : CT_LATE;
      end

      if (cas_rise) begin
        cas_acc   <= 1'b0;
        early_wr  <= 1'b0;
        late_done <= 1'b0;
        dvalid    <= 1'b0;
        oe_seen   <= 1'b0;
      end
    end
  end

  assert_rd_wr_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_stb));

  assert_wr_cas_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(!cas_n));

  assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_stb && (cyc_type == CT_CBR || cyc_type == CT_HIDDEN)) |->
      (rfsh_cnt == ((rfsh_row + 1'b1) & ROW_MASK)));

  assert_ronly_hiz_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_stb && cyc_type == CT_RONLY) |-> !dq_oe);

  assert_self_ras_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
    self_rfsh |-> $past(!ras_n));

  assert_oe_cas_held_R14: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(!cas_n));
endmodule

// File: tb/sim_fpm_strobe_decoder.sv
`timescale 1ns/1ps
module sim_fpm_strobe_decoder;
  localparam int SC = 40;
  localparam logic [11:0] ROW_A = 12'hA5D;
  localparam logic [11:0] ROW_R = 12'h3C1;
  localparam logic [11:0] COL_A = 12'hC13;
  localparam logic [11:0] COL_B = 12'h005;
  localparam logic [11:0] COL_C = 12'h006;
  localparam logic [11:0] COL_D = 12'h007;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [11:0] addr = '0;
  logic [3:0] din = '0;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;
  logic [11:0] exp_cnt = '0;

  logic [3:0] dq_out, wr_data, dq_out1, wr_data1;
  logic dq_oe, rd_en, wr_stb, rfsh_stb, self_rfsh;
  logic dq_oe1, rd_en1, wr_stb1, rfsh_stb1, self_rfsh1;
  logic [11:0] row_q, col_q, rfsh_row, rfsh_cnt;
  logic [11:0] row_q1, col_q1, rfsh_row1, rfsh_cnt1;
  logic [2:0] cyc_type, cyc_type1;

  always #4 clk = ~clk;

  fpm_strobe_decoder #(.MODE_4K(1), .SELF_CYC(SC)) u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(din), .dq_out(dq_out), .dq_oe(dq_oe), .row_q(row_q), .col_q(col_q),
    .rd_en(rd_en), .wr_stb(wr_stb), .wr_data(wr_data), .rfsh_stb(rfsh_stb),
    .rfsh_row(rfsh_row), .rfsh_cnt(rfsh_cnt), .self_rfsh(self_rfsh), .cyc_type(cyc_type));

  fpm_strobe_decoder #(.MODE_4K(0), .SELF_CYC(SC)) u1 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(din), .dq_out(dq_out1), .dq_oe(dq_oe1), .row_q(row_q1), .col_q(col_q1),
    .rd_en(rd_en1), .wr_stb(wr_stb1), .wr_data(wr_data1), .rfsh_stb(rfsh_stb1),
    .rfsh_row(rfsh_row1), .rfsh_cnt(rfsh_cnt1), .self_rfsh(self_rfsh1), .cyc_type(cyc_type1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tk(input logic r, input logic c, input logic w, input logic o,
                    input logic [11:0] a, input logic [3:0] d);
    ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a; din = d;
    @(negedge clk);
  endtask

  task automatic read_back(input logic [11:0] col, input logic [3:0] exp, input string tag);
    tk(0, 1, 1, 1, ROW_A, 0);
    tk(0, 0, 1, 0, col, 0);
    chk({tag, " readback dq_out"}, dq_out, exp);
    chk({tag, " readback dq_oe"}, dq_oe, 1);
    tk(0, 1, 1, 1, 0, 0);
    tk(1, 1, 1, 1, 0, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 dq_oe in reset", dq_oe, 0);
    chk("R1 rfsh_cnt in reset", rfsh_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_en", rd_en, 0);
    chk("R1 wr_stb", wr_stb, 0);
    chk("R1 rfsh_stb", rfsh_stb, 0);
    chk("R1 self_rfsh", self_rfsh, 0);
    chk("R1 cyc_type", cyc_type, 0);
    chk("R1 rfsh_cnt", rfsh_cnt, 0);
  endtask

  task automatic t_early;
    tk(1, 1, 1, 1, 0, 0);
    tk(0, 1, 1, 1, ROW_A, 0);
    chk("R2 row wide", row_q, 12'hA5D);
    chk("R2 row balanced", row_q1, 12'h25D);
    tk(0, 1, 0, 0, 0, 0);
    tk(0, 0, 0, 0, COL_A, 4'h9);
    chk("R3 col wide", col_q, 12'h013);
    chk("R3 col balanced", col_q1, 12'h413);
    chk("R5 wr_stb", wr_stb, 1);
    chk("R5 wr_data", wr_data, 4'h9);
    chk("R5 cyc_type", cyc_type, 2);
    chk("R5 dq_oe at fall", dq_oe, 0);
    tk(0, 0, 0, 0, COL_A, 4'h9);
    chk("R5 dq_oe held", dq_oe, 0);
    chk("R5 single strobe", wr_stb, 0);
    tk(0, 1, 1, 1, 0, 0);
    tk(1, 1, 1, 1, 0, 0);
  endtask

  task automatic t_read;
    tk(0, 1, 1, 1, ROW_A, 0);
    tk(0, 0, 1, 0, COL_A, 0);
    chk("R4 rd_en", rd_en, 1);
    chk("R4 cyc_type", cyc_type, 1);
    chk("R4 dq_oe", dq_oe, 1);
    chk("R4 dq_out", dq_out, 4'h9);
    tk(0, 0, 1, 1, COL_A, 0);
    chk("R4 rd_en pulse", rd_en, 0);
    chk("R14 oe high", dq_oe, 0);
    tk(0, 0, 1, 0, COL_A, 0);
    chk("R14 oe low again", dq_oe, 1);
    tk(0, 1, 1, 0, 0, 0);
    chk("R14 cas high", dq_oe, 0);
    tk(1, 1, 1, 1, 0, 0);
  endtask

  task automatic t_late;
    tk(0, 1, 1, 1, ROW_A, 0);
    tk(0, 0, 1, 1, COL_B, 0);
    chk("R6 no drive", dq_oe, 0);
    tk(0, 0, 0, 1, COL_B, 4'h6);
    chk("R6 wr_stb", wr_stb, 1);
    chk("R6 wr_data", wr_data, 4'h6);
    chk("R6 cyc_type", cyc_type, 3);
    tk(0, 0, 0, 1, COL_B, 4'h6);
    chk("R6 single strobe", wr_stb, 0);
    tk(0, 1, 1, 1, 0, 0);
    tk(1, 1, 1, 1, 0, 0);
    read_back(COL_B, 4'h6, "R6");
  endtask

  task automatic t_rmw;
    tk(0, 1, 1, 1, ROW_A, 0);
    tk(0, 0, 1, 0, COL_C, 0);
    tk(0, 0, 1, 0, COL_C, 0);
    tk(0, 0, 1, 1, COL_C, 4'hA);
    chk("R7 released", dq_oe, 0);
    tk(0, 0, 0, 1, COL_C, 4'hA);
    chk("R7 wr_stb", wr_stb, 1);
    chk("R7 cyc_type", cyc_type, 4);
    chk("R7 wr_data", wr_data, 4'hA);
    tk(0, 1, 1, 1, 0, 0);
    tk(1, 1, 1, 1, 0, 0);
    read_back(COL_C, 4'hA, "R7");
  endtask

  task automatic t_blocked;
    tk(0, 1, 1, 1, ROW_A, 0);
    tk(0, 0, 1, 0, COL_B, 0);
    chk("R8 read first", dq_out, 4'h6);
    tk(0, 0, 0, 0, COL_B, 4'hF);
    chk("R8 no wr_stb", wr_stb, 0);
    chk("R8 still drives", dq_oe, 1);
    chk("R8 dq_out kept", dq_out, 4'h6);
    chk("R8 cyc_type read", cyc_type, 1);
    tk(0, 0, 0, 0, COL_B, 4'hF);
    chk("R8 still drives later", dq_oe, 1);
    tk(0, 1, 1, 1, 0, 0);
    tk(1, 1, 1, 1, 0, 0);
    read_back(COL_B, 4'h6, "R8");
  endtask

  task automatic t_page;
    tk(0, 1, 1, 1, ROW_A, 0);
    tk(0, 0, 1, 0, COL_A, 0);
    chk("R9 first column", dq_out, 4'h9);
    tk(0, 1, 1, 0, 0, 0);
    tk(0, 0, 1, 0, COL_B, 0);
    chk("R9 second column", dq_out, 4'h6);
    chk("R9 rd_en", rd_en, 1);
    chk("R9 row kept", row_q, 12'hA5D);
    chk("R9 col", col_q, 12'h005);
    tk(0, 1, 1, 0, 0, 0);
    tk(0, 0, 0, 1, COL_D, 4'h3);
    chk("R9 page write", wr_stb, 1);
    tk(0, 1, 1, 1, 0, 0);
    tk(0, 0, 1, 0, COL_D, 0);
    chk("R9 page readback", dq_out, 4'h3);
    tk(0, 1, 1, 1, 0, 0);
    tk(1, 1, 1, 1, 0, 0);
    chk("R9 close no refresh", rfsh_stb, 0);
    tk(1, 0, 1, 0, COL_A, 0);
    chk("R9 no access rd_en", rd_en, 0);
    chk("R9 no access dq_oe", dq_oe, 0);
    tk(1, 1, 1, 1, 0, 0);
  endtask

  task automatic t_cbr;
    for (int i = 0; i < 2; i++) begin
      tk(1, 1, 1, 1, 0, 0);
      tk(1, 0, 1, 0, 12'hFFF, 0);
      tk(0, 0, 1, 0, 12'hFFF, 0);
      chk("R10 rfsh_stb", rfsh_stb, 1);
      chk("R10 rfsh_row", rfsh_row, exp_cnt);
      chk("R10 rfsh_cnt", rfsh_cnt, exp_cnt + 1);
      chk("R10 cyc_type", cyc_type, 6);
      chk("R10 dq_oe", dq_oe, 0);
      chk("R10 row untouched", row_q, 12'hA5D);
      exp_cnt = exp_cnt + 1;
      tk(0, 0, 1, 0, 12'hFFF, 0);
      chk("R10 pulse", rfsh_stb, 0);
      tk(1, 0, 1, 0, 0, 0);
      tk(1, 1, 1, 1, 0, 0);
    end
  endtask

  task automatic t_hidden;
    tk(0, 1, 1, 1, ROW_A, 0);
    tk(0, 0, 1, 0, COL_A, 0);
    chk("R11 read", dq_out, 4'h9);
    tk(1, 0, 1, 0, 0, 0);
    chk("R11 drive in precharge", dq_oe, 1);
    tk(1, 0, 1, 0, 0, 0);
    tk(0, 0, 1, 0, 12'h777, 0);
    chk("R11 rfsh_stb", rfsh_stb, 1);
    chk("R11 cyc_type", cyc_type, 7);
    chk("R11 rfsh_row", rfsh_row, exp_cnt);
    chk("R11 dq_oe", dq_oe, 1);
    chk("R11 dq_out", dq_out, 4'h9);
    exp_cnt = exp_cnt + 1;
    tk(1, 0, 1, 0, 0, 0);
    tk(1, 1, 1, 0, 0, 0);
    chk("R11 released", dq_oe, 0);
  endtask

  task automatic t_rasonly;
    tk(0, 1, 1, 0, ROW_R, 0);
    tk(0, 1, 1, 0, 0, 0);
    chk("R12 no early strobe", rfsh_stb, 0);
    tk(1, 1, 1, 0, 0, 0);
    chk("R12 rfsh_stb", rfsh_stb, 1);
    chk("R12 rfsh_row", rfsh_row, 12'h3C1);
    chk("R12 cyc_type", cyc_type, 5);
    chk("R12 dq_oe", dq_oe, 0);
    chk("R12 counter kept", rfsh_cnt, exp_cnt);
    tk(1, 1, 1, 1, 0, 0);
  endtask

  task automatic t_self;
    tk(1, 0, 1, 1, 0, 0);
    tk(0, 0, 1, 1, 0, 0);
    exp_cnt = exp_cnt + 1;
    for (int i = 0; i < SC - 1; i++) tk(0, 0, 1, 1, 0, 0);
    chk("R13 not yet", self_rfsh, 0);
    tk(0, 0, 1, 1, 0, 0);
    chk("R13 entered", self_rfsh, 1);
    chk("R13 counter", rfsh_cnt, exp_cnt);
    tk(1, 0, 1, 1, 0, 0);
    chk("R13 exit", self_rfsh, 0);
    tk(1, 1, 1, 1, 0, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_early;
    t_read;
    t_late;
    t_rmw;
    t_blocked;
    t_page;
    t_cbr;
    t_hidden;
    t_rasonly;
    t_self;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule